// File: doc/BRIEF.md
# Prescaled Serial Bit-Rate Timer

This block derives every timing pulse a serial controller needs from the bus clock. The bus clock is the CPU clock divided by four. The timer divides the bus clock by the product of two factors. The first is a prescaler of 1, 3, 4 or 13. The second is a binary rate divider of 2^N, where N runs from 0 to 7. The result is a single-cycle oversample pulse. Every sixteenth oversample pulse becomes a bit-period strobe. A frame strobe marks the end of each character, which is 10 or 11 bit times long.

Software sets the rate through a byte-wide register bus. Address 0 holds the rate register. Address 1 holds the frame-length control. Any write restarts all of the dividers, so the pulse train is always in phase with the most recent configuration. At reset the rate register clears, unless the part is starting in bootstrap mode. In that case reset preloads a fixed rate, so that a loader can talk at once.

Top module: `baud_timer`

## Requirements
- R1: During and after a normal reset, the rate register (address 0) reads 0x00 and the frame control (address 1) reads 0x00.
- R2: When reset occurs with `smod`=1 and `mda`=0 (bootstrap), the rate register reads 0x33 and oversample pulses come every 104 clocks. With `mda`=1 it reads 0x00.
- R3: `os_tick` is a one-cycle pulse every P×2^N clocks. N is rate bits [2:0]. P is set by rate bits [5:4]: 00→1, 01→3, 10→4, 11→13.
- R4: `bit_tick` is high exactly on every 16th `os_tick`, counted from the last restart. The first one comes 16×P×2^N clocks after a restart.
- R5: Frame control bit 4 selects the frame length: 0 gives 10 bit periods and 1 gives 11. `frame_tick` coincides with the last `bit_tick` of each frame.
- R6: Any bus write, to either address, restarts every counter. The first `os_tick` then comes a full P×2^N clocks after the write edge.
- R7: Rate bits 7 and 3 are stored and read back but leave the timing unchanged. Rate bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (CPU clock / 4) |
| rst_n | input | 1 | Asynchronous active-low reset |
| smod | input | 1 | Special-mode strap, sampled during reset |
| mda | input | 1 | Mode-A strap, sampled during reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = rate register, 1 = frame control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| os_tick | output | 1 | 16x oversample pulse |
| bit_tick | output | 1 | One-bit-period strobe |
| frame_tick | output | 1 | End-of-frame strobe |

## Verification
On every cycle, the bound checker tracks its own copy of the configuration. Against that copy it checks four things: the gap between oversample pulses, the sixteen-pulse grouping into bit strobes, the frame length in bit strobes, and the silence right after a write. Only the bench scenarios can show the absolute values. These are the reset and bootstrap register contents, the exact divisor for each prescaler encoding, the readback of the test bits and of the zero bit, and that the test bits leave the period unchanged.

// File: rtl/baud_timer.sv
module baud_timer #(
  parameter int DW  = 8,
  parameter int CW  = 11,
  parameter int OVS = 16,
  parameter int FW  = 4,
  parameter int SHORT_LEN = 10,
  parameter int LONG_LEN  = 11,
  parameter logic [DW-1:0] BOOT_RATE = 8'h33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smod,
  input  logic          mda,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          os_tick,
  output logic          bit_tick,
  output logic          frame_tick
);
  localparam int SW = $clog2(OVS);

  logic [DW-1:0] rate_q;
  logic          long_q;
  logic [3:0]    pre;
  logic [CW-1:0] div;
  logic [CW-1:0] os_cnt;
  logic [SW-1:0] sub_cnt;
  logic [FW-1:0] frm_cnt;
  logic [FW-1:0] flen;

  always_comb begin
    case (rate_q[5:4])
      2'b00:   pre = 4'd1;
      2'b01:   pre = 4'd3;
      2'b10:   pre = 4'd4;
      default: pre = 4'd13;
    endcase
  end

  assign div        = CW'(pre) << rate_q[2:0];
  assign flen       = long_q ? FW'(LONG_LEN) : FW'(SHORT_LEN);
  assign os_tick    = (os_cnt == div - CW'(1));
  assign bit_tick   = os_tick && (sub_cnt == SW'(OVS - 1));
  assign frame_tick = bit_tick && (frm_cnt == flen - FW'(1));
  assign rd_data    = addr ? DW'({long_q, 4'b0000}) : rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= (smod && !mda) ? BOOT_RATE : '0;
      long_q <= 1'b0;
    end else if (wr_en) begin
      if (addr) long_q <= wr_data[4];
      else      rate_q <= wr_data & 8'hBF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_cnt  <= '0;
      sub_cnt <= '0;
      frm_cnt <= '0;
    end else if (wr_en) begin
      os_cnt  <= '0;
      sub_cnt <= '0;
      frm_cnt <= '0;
    end else if (os_tick) begin
      os_cnt  <= '0;
      sub_cnt <= sub_cnt + SW'(1);
      if (bit_tick) frm_cnt <= frame_tick ? '0 : frm_cnt + FW'(1);
    end else begin
      os_cnt <= os_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/baud_timer_chk.sv
module baud_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smod,
  input logic       mda,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wr_data,
  input logic       os_tick,
  input logic       bit_tick,
  input logic       frame_tick
);
  logic [7:0]  sh_rate;
  logic        sh_long;
  logic [11:0] gap;
  logic [3:0]  os_seen;
  logic [3:0]  bits_seen;
  logic [11:0] sh_div;
  logic [11:0] nx_div;

  function automatic logic [11:0] divof(input logic [7:0] r);
    logic [11:0] p;
    p = (r[5:4] == 2'd0) ? 12'd1 : (r[5:4] == 2'd1) ? 12'd3 :
        (r[5:4] == 2'd2) ? 12'd4 : 12'd13;
    return p << r[2:0];
  endfunction

  assign sh_div = divof(sh_rate);
  assign nx_div = addr ? sh_div : divof(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_rate <= (smod && !mda) ? 8'h33 : 8'h00;
      sh_long <= 1'b0;
      gap <= '0; os_seen <= '0; bits_seen <= '0;
    end else if (wr_en) begin
      if (addr) sh_long <= wr_data[4]; else sh_rate <= wr_data;
      gap <= '0; os_seen <= '0; bits_seen <= '0;
    end else begin
      gap <= os_tick ? 12'd0 : gap + 12'd1;
      if (os_tick) begin
        os_seen <= os_seen + 4'd1;
        if (os_seen == 4'd15)
          bits_seen <= (bits_seen == (sh_long ? 4'd10 : 4'd9)) ? 4'd0 : bits_seen + 4'd1;
      end
    end
  end

  p_os_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> gap == sh_div - 12'd1);
  p_bit_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> (bit_tick == (os_seen == 4'd15)));
  p_frame_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (frame_tick == (bits_seen == (sh_long ? 4'd10 : 4'd9))));
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && nx_div != 12'd1) |=> !os_tick);
endmodule

bind baud_timer baud_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smod(smod), .mda(mda), .wr_en(wr_en),
  .addr(addr), .wr_data(wr_data), .os_tick(os_tick), .bit_tick(bit_tick),
  .frame_tick(frame_tick)
);

// File: tb/sim_baud_timer.sv
module sim_baud_timer;
  localparam int PERIOD = 10;
  localparam int NV = 8;
  localparam logic [7:0] VAL [NV] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h05, 8'h17, 8'h37, 8'h23};
  localparam int         DIV [NV] = '{1, 3, 4, 13, 32, 384, 1664, 32};

  logic clk = 0, rst_n = 0, smod = 0, mda = 0, wr_en = 0, addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic os_tick, bit_tick, frame_tick;
  int checks = 0, errors = 0, cyc = 0;

  baud_timer u0 (.clk(clk), .rst_n(rst_n), .smod(smod), .mda(mda), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .os_tick(os_tick),
    .bit_tick(bit_tick), .frame_tick(frame_tick));

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic waitfor(input int sel, output int n);
    n = 1;
    while (!(sel == 0 ? os_tick : sel == 1 ? bit_tick : frame_tick) && n < 4000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic do_reset(input logic s, input logic m);
    @(negedge clk); smod = s; mda = m; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    int n;
    @(negedge clk);
    addr = 0; #1 chk("R1 rate reset", rd_data, 8'h00);
    rst_n = 1;
    @(negedge clk);
    addr = 0; #1 chk("R1 rate after reset", rd_data, 8'h00);
    addr = 1; #1 chk("R1 ctrl after reset", rd_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(0, VAL[i]);
      waitfor(0, n); chk("R6 first tick after write", n, DIV[i]);
      @(negedge clk); waitfor(0, n); chk("R3 tick period", n, DIV[i]);
    end

    wr(0, 8'h00);
    waitfor(1, n); chk("R4 first bit strobe", n, 16);
    @(negedge clk); waitfor(1, n); chk("R4 bit period", n, 16);

    wr(1, 8'h00);
    waitfor(2, n); chk("R5 short frame", n, 160);
    wr(1, 8'h10);
    addr = 1; #1 chk("R5 ctrl readback", rd_data, 8'h10);
    waitfor(2, n); chk("R6 R5 long frame after ctrl write", n, 176);
    @(negedge clk); waitfor(2, n); chk("R5 long frame period", n, 176);

    wr(0, 8'h8D);
    addr = 0; #1 chk("R7 test bits readback", rd_data, 8'h8D);
    waitfor(0, n); chk("R7 test bits no effect", n, 32);
    wr(0, 8'hFF);
    addr = 0; #1 chk("R7 bit6 reads zero", rd_data, 8'hBF);

    do_reset(1, 0);
    addr = 0; #1 chk("R2 boot preload", rd_data, 8'h33);
    waitfor(0, n); @(negedge clk); waitfor(0, n); chk("R2 boot period", n, 104);
    do_reset(1, 1);
    addr = 0; #1 chk("R2 mda set no preload", rd_data, 8'h00);
    do_reset(0, 0);
    addr = 0; #1 chk("R1 normal reset", rd_data, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule